// File: doc/BRIEF.md
# Predict-Taken Branch Resolution Controller

This controller sits in the instruction-fetch unit and resolves the simpler branch kinds under a policy that predicts every branch taken. When decode presents a branch, the controller captures its target and condition. In the very next cycle it issues a speculative fetch request to memory at that target, before anything is known about the outcome.

For a conditional or loop-style branch the controller then waits for a sync pulse from the execute unit. That pulse warns that the condition codes will be valid one clock later. In that later cycle the zero flag is compared against the branch's condition. When the prediction holds, the controller flushes the prefetch and decode stages and points the instruction stream at the target. When the prediction fails, it kills the speculative access and leaves the prefetched bytes to continue.

An unconditional branch needs no sync and goes straight to the redirect. Any other branch kind is handed to the execute unit and starts no speculative fetch. The controller takes one branch at a time and is ready again only once it has returned to idle.

Top module: `ptbr_top`

## Requirements
- R1: While reset is held and after it is released with no branch offered, the controller is ready (`br_ready`=1), and `mem_req`, `mem_abort`, `flush`, `redirect_valid` and `defer_exec` are all 0.
- R2: A branch accepted at a clock edge (`br_valid`=1 with `br_ready`=1, kind 00, 01 or 10) raises `mem_req` for exactly the one following cycle, with `mem_addr` equal to the captured target, even if `br_target` changes afterwards.
- R3: For kind 01 (unconditional), `flush` and `redirect_valid` are 1 in the cycle after the request cycle, with `redirect_addr` equal to the target and no sync required. The controller is ready in the cycle after that.
- R4: For kinds 00 and 10, the controller waits with no flush and no abort for as long as `cc_sync` stays low. A `cc_sync` sampled high during the wait makes the next cycle the evaluation cycle, and `cc_z` is sampled at the end of that cycle.
- R5: The condition bit `br_cond_ne`=0 predicts correctly when the sampled Z is 1. `br_cond_ne`=1 predicts correctly when the sampled Z is 0.
- R6: When the prediction holds, `flush` and `redirect_valid` are 1 for the single cycle after the evaluation cycle, with `redirect_addr` equal to the target and `mem_abort`=0. The controller is ready in the cycle after that.
- R7: When the prediction fails, `mem_abort` is 1 for the single cycle after the evaluation cycle with `flush`=0, and the controller is already ready in that cycle.
- R8: A `cc_sync` sampled high during the request cycle of a conditional branch counts as the sync, so the evaluation cycle directly follows the request cycle.
- R9: Kind 11 is not resolved here. Accepting it pulses `defer_exec` for one cycle, issues no `mem_req`, and leaves the controller ready.
- R10: `br_valid` offered while the controller is busy is ignored: no new request is made, and the pending branch still resolves to its own target.
- R11: `cc_sync` while idle and `cc_z` outside the evaluation cycle have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| br_valid | input | 1 | Decode presents a branch |
| br_kind | input | 2 | 00 conditional, 01 unconditional, 10 loop, 11 other |
| br_cond_ne | input | 1 | 0: predicted taken on Z=1; 1: on Z=0 |
| br_target | input | ADDR_W | Computed branch target |
| br_ready | output | 1 | Controller idle and able to accept |
| mem_req | output | 1 | Speculative fetch request |
| mem_addr | output | ADDR_W | Address of the speculative fetch |
| mem_abort | output | 1 | Kill the outstanding speculative fetch |
| cc_sync | input | 1 | Condition codes valid on the next clock |
| cc_z | input | 1 | Zero condition-code flag |
| flush | output | 1 | Flush prefetch and decode stages |
| redirect_valid | output | 1 | Load instruction stream from redirect_addr |
| redirect_addr | output | ADDR_W | Redirect target |
| defer_exec | output | 1 | Branch handed to the execute unit |

## Verification
All outputs are registered or decoded from state, so each result appears one clock after its cause. The request follows acceptance by one cycle. The redirect of an unconditional branch follows the request by one cycle. The evaluation cycle follows the sampled sync by one cycle, and the flush or abort follows the evaluation cycle by one cycle. The bench drives inputs and samples outputs 1 ns after each rising edge, and it steps through that count of edges before each check. It sweeps every resolvable kind, both condition senses, both flag values and sync delays of zero to three cycles. During waits it drives the inverse flag so that a wrong sampling cycle is caught.

// File: rtl/ptbr_pkg.sv
package ptbr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_FETCH = 3'd1,
    ST_WAIT  = 3'd2,
    ST_EVAL  = 3'd3,
    ST_REDIR = 3'd4
  } ptbr_state_e;

  typedef enum logic [1:0] {
    BK_COND   = 2'b00,
    BK_ALWAYS = 2'b01,
    BK_LOOP   = 2'b10,
    BK_OTHER  = 2'b11
  } ptbr_kind_e;

  // Prediction holds when the flag matches the requested sense.
  function automatic logic ptbr_hit(input logic ne_sel, input logic z);
    return ne_sel ? ~z : z;
  endfunction

endpackage

// File: rtl/ptbr_rst_sync.sv
module ptbr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[LAST-1:0], 1'b1};
  end

  assign rst_n_sync = chain_q[LAST];
endmodule

// File: rtl/ptbr_hold.sv
module ptbr_hold #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [ADDR_W-1:0] d_target,
  input  logic              d_ne,
  input  logic              d_always,
  output logic [ADDR_W-1:0] q_target,
  output logic              q_ne,
  output logic              q_always
);
  logic [ADDR_W-1:0] target_d;
  logic              ne_d;
  logic              always_d;

  always_comb begin
    target_d = q_target;
    ne_d     = q_ne;
    always_d = q_always;
    if (load_en) begin
      target_d = d_target;
      ne_d     = d_ne;
      always_d = d_always;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_target <= '0;
      q_ne     <= 1'b0;
      q_always <= 1'b0;
    end else begin
      q_target <= target_d;
      q_ne     <= ne_d;
      q_always <= always_d;
    end
  end
endmodule

// File: rtl/ptbr_fsm.sv
module ptbr_fsm
  import ptbr_pkg::*;
#(
  parameter bit EARLY_SYNC = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        is_always,
  input  logic        cc_sync,
  input  logic        hit,
  output ptbr_state_e state
);
  ptbr_state_e state_d;
  logic        early_sync;

  generate
    if (EARLY_SYNC) begin : g_early
      assign early_sync = cc_sync;
    end else begin : g_late
      assign early_sync = 1'b0;
    end
  endgenerate

  always_comb begin
    state_d = state;
    unique case (state)
      ST_IDLE:  if (start) state_d = ST_FETCH;
      ST_FETCH: begin
        if (is_always)       state_d = ST_REDIR;
        else if (early_sync) state_d = ST_EVAL;
        else                 state_d = ST_WAIT;
      end
      ST_WAIT:  if (cc_sync) state_d = ST_EVAL;
      ST_EVAL:  state_d = hit ? ST_REDIR : ST_IDLE;
      ST_REDIR: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_d;
  end

  AST_SYNC_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT && cc_sync) |=> (state == ST_EVAL)); // R4
  AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT && !cc_sync) |=> (state == ST_WAIT)); // R4
  AST_ALWAYS_SKIPS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FETCH && is_always) |=> (state == ST_REDIR)); // R3
endmodule

// File: rtl/ptbr_top.sv
module ptbr_top
  import ptbr_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter bit EARLY_SYNC = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              br_valid,
  input  logic [1:0]        br_kind,
  input  logic              br_cond_ne,
  input  logic [ADDR_W-1:0] br_target,
  output logic              br_ready,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_abort,
  input  logic              cc_sync,
  input  logic              cc_z,
  output logic              flush,
  output logic              redirect_valid,
  output logic [ADDR_W-1:0] redirect_addr,
  output logic              defer_exec
);
  logic              rst_n_s;
  ptbr_state_e       state;
  logic              accept;
  logic              start;
  logic              kind_always;
  logic              kind_other;
  logic [ADDR_W-1:0] held_target;
  logic              held_ne;
  logic              held_always;
  logic              hit;
  logic              abort_d, abort_q;
  logic              defer_d, defer_q;

  ptbr_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  assign kind_always = (br_kind == BK_ALWAYS);
  assign kind_other  = (br_kind == BK_OTHER);
  assign accept      = br_valid && (state == ST_IDLE);
  assign start       = accept && !kind_other;
  assign hit         = ptbr_hit(held_ne, cc_z);

  ptbr_hold #(.ADDR_W(ADDR_W)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .load_en  (start),
    .d_target (br_target),
    .d_ne     (br_cond_ne),
    .d_always (kind_always),
    .q_target (held_target),
    .q_ne     (held_ne),
    .q_always (held_always)
  );

  ptbr_fsm #(.EARLY_SYNC(EARLY_SYNC)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .start     (start),
    .is_always (held_always),
    .cc_sync   (cc_sync),
    .hit       (hit),
    .state     (state)
  );

  assign abort_d = (state == ST_EVAL) && !hit;
  assign defer_d = accept && kind_other;

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      abort_q <= 1'b0;
      defer_q <= 1'b0;
    end else begin
      abort_q <= abort_d;
      defer_q <= defer_d;
    end
  end

  assign br_ready       = (state == ST_IDLE);
  assign mem_req        = (state == ST_FETCH);
  assign mem_addr       = held_target;
  assign mem_abort      = abort_q;
  assign flush          = (state == ST_REDIR);
  assign redirect_valid = (state == ST_REDIR);
  assign redirect_addr  = held_target;
  assign defer_exec     = defer_q;

  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n_s)
    mem_req |=> !mem_req); // R2
  AST_RESOLVE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n_s)
    !(mem_abort && flush)); // R7
  AST_ABORT_FROM_EVAL: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(mem_abort) |-> $past(state == ST_EVAL)); // R7
  AST_BUSY_KEEPS_TARGET: assert property (@(posedge clk) disable iff (!rst_n_s)
    !br_ready |=> $stable(mem_addr)); // R10
  AST_DEFER_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n_s)
    defer_exec |-> (!mem_req && br_ready)); // R9
endmodule

// File: tb/ptbr_top_tb.sv
module ptbr_top_tb;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          br_valid;
  logic [1:0]    br_kind;
  logic          br_cond_ne;
  logic [AW-1:0] br_target;
  logic          br_ready;
  logic          mem_req;
  logic [AW-1:0] mem_addr;
  logic          mem_abort;
  logic          cc_sync;
  logic          cc_z;
  logic          flush;
  logic          redirect_valid;
  logic [AW-1:0] redirect_addr;
  logic          defer_exec;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  ptbr_top #(.ADDR_W(AW)) u_dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .br_valid       (br_valid),
    .br_kind        (br_kind),
    .br_cond_ne     (br_cond_ne),
    .br_target      (br_target),
    .br_ready       (br_ready),
    .mem_req        (mem_req),
    .mem_addr       (mem_addr),
    .mem_abort      (mem_abort),
    .cc_sync        (cc_sync),
    .cc_z           (cc_z),
    .flush          (flush),
    .redirect_valid (redirect_valid),
    .redirect_addr  (redirect_addr),
    .defer_exec     (defer_exec)
  );

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic int quiet_bits();
    return {mem_req, mem_abort, flush, redirect_valid, defer_exec};
  endfunction

  task automatic run_branch(input logic [1:0] kind, input logic ne, input logic z,
                            input int dly, input logic [AW-1:0] tgt);
    logic exp_hit;
    exp_hit    = ne ? ~z : z;
    br_valid   = 1'b1;
    br_kind    = kind;
    br_cond_ne = ne;
    br_target  = tgt;
    cc_z       = ~z;
    tick;
    br_valid  = 1'b0;
    br_target = ~tgt;
    chk(mem_req == 1'b1, "R2 request raised", mem_req, 1);
    chk(mem_addr == tgt, "R2 request address", mem_addr, tgt);
    if (kind == 2'b01) begin
      tick;
      chk(flush && redirect_valid, "R3 redirect flags", {flush, redirect_valid}, 3);
      chk(redirect_addr == tgt, "R3 redirect address", redirect_addr, tgt);
      chk(!mem_abort && !mem_req, "R3 no abort", {mem_abort, mem_req}, 0);
      tick;
      chk(br_ready && !flush, "R3 ready after", {br_ready, flush}, 2);
    end else begin
      if (dly == 0) cc_sync = 1'b1;
      tick;
      cc_sync = 1'b0;
      if (dly > 0) begin
        chk(mem_req == 1'b0, "R2 single cycle", mem_req, 0);
        for (int i = 1; i < dly; i++) begin
          chk(!flush && !mem_abort && !br_ready, "R4 waiting",
              {flush, mem_abort, br_ready}, 0);
          tick;
        end
        cc_sync = 1'b1;
        tick;
        cc_sync = 1'b0;
      end else begin
        chk(!mem_req && !br_ready && !flush, "R8 early sync eval",
            {mem_req, br_ready, flush}, 0);
      end
      cc_z = z;
      chk(!flush && !mem_abort, "R4 eval cycle quiet", {flush, mem_abort}, 0);
      tick;
      cc_z = ~z;
      if (exp_hit) begin
        chk(flush && redirect_valid, "R6 R5 taken flags", {flush, redirect_valid}, 3);
        chk(redirect_addr == tgt, "R6 redirect address", redirect_addr, tgt);
        chk(!mem_abort, "R5 no abort when taken", mem_abort, 0);
        tick;
        chk(br_ready && !flush, "R6 ready after", {br_ready, flush}, 2);
      end else begin
        chk(mem_abort && !flush, "R7 R5 abort", {mem_abort, flush}, 2);
        chk(br_ready, "R7 ready with abort", br_ready, 1);
        tick;
        chk(!mem_abort, "R7 abort one cycle", mem_abort, 0);
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog R1 act=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n      = 1'b0;
    br_valid   = 1'b0;
    br_kind    = 2'b00;
    br_cond_ne = 1'b0;
    br_target  = '0;
    cc_sync    = 1'b0;
    cc_z       = 1'b0;
    tick;
    tick;
    chk(br_ready && quiet_bits() == 0, "R1 in reset", quiet_bits(), 0);
    rst_n = 1'b1;
    repeat (4) tick;
    chk(br_ready && quiet_bits() == 0, "R1 after reset", quiet_bits(), 0);

    // Sweep resolvable kinds, both senses, both flags, sync delays 0..3
    for (int k = 0; k < 3; k++)
      for (int n = 0; n < 2; n++)
        for (int z = 0; z < 2; z++)
          for (int d = 0; d < 4; d++)
            run_branch(k[1:0], n[0], z[0], d, AW'(16'h1000 + k*256 + n*64 + z*16 + d));

    // R9: other kind deferred to execute
    br_valid = 1'b1; br_kind = 2'b11; br_target = 16'hBEEF;
    tick;
    br_valid = 1'b0;
    chk(defer_exec && !mem_req && br_ready, "R9 defer pulse",
        {defer_exec, mem_req, br_ready}, 5);
    tick;
    chk(!defer_exec && !mem_req, "R9 defer one cycle", {defer_exec, mem_req}, 0);

    // R11: sync and flag while idle
    cc_sync = 1'b1;
    for (int i = 0; i < 3; i++) begin
      cc_z = i[0];
      tick;
      chk(br_ready && quiet_bits() == 0, "R11 idle sync ignored", quiet_bits(), 0);
    end
    cc_sync = 1'b0;

    // R10: branch offered while busy
    br_valid = 1'b1; br_kind = 2'b00; br_cond_ne = 1'b0; br_target = 16'h4A4A;
    tick;
    br_target = 16'h7777;
    tick;
    chk(!br_ready && !mem_req, "R10 busy", {br_ready, mem_req}, 0);
    br_kind = 2'b01;
    tick;
    br_valid = 1'b0;
    chk(!mem_req && !flush, "R10 no new request", {mem_req, flush}, 0);
    cc_sync = 1'b1;
    tick;
    cc_sync = 1'b0;
    cc_z = 1'b1;
    tick;
    cc_z = 1'b0;
    chk(flush && redirect_addr == 16'h4A4A, "R10 keeps first target", redirect_addr, 16'h4A4A);
    tick;
    chk(br_ready && quiet_bits() == 0, "R10 back to idle", quiet_bits(), 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule